// File: doc/BRIEF.md
# Nonvolatile Save/Restore Controller

This block sequences transfers between a fast SRAM array and the nonvolatile shadow array that sits beside it. A save copies SRAM contents into the shadow array in two phases: erase, then program. A restore brings the shadow contents back in two phases: clear the SRAM, then copy. Each phase lasts a parameterised number of clock cycles. The block drives the phase strobes of the array and pulses `done` once a sequence has finished. Analog sensing is outside the block. The supply comparators arrive as two digital flags: `supply_ok` means the supply is above the switch threshold, and `supply_dead` means it is below the reset threshold.

A save can be requested in three ways: a software command, an external store pin pulled low, or a supply that falls below the switch threshold. A restore can be requested by a software command, or it is latched at power-up and on a deep supply drop. A dirty flag records whether any SRAM write has been accepted since the last save or restore. Pin and power-fail saves depend on that flag; software saves ignore it.

During any save the block pulls the shared busy pin low through an open-drain model, given as an enable plus a level. After the save it stays locked until the pin is seen high again. The block also gates every SRAM read and write strobe. A pin-initiated save starts with a grace window. During that window reads still proceed and a write already under way may finish.

Top module: `nvsr_ctrl`

## Requirements
- R1: The dirty flag is set by every granted write and cleared when any save or restore starts. A save requested by the store pin or by power-fail (`supply_ok` low) runs its erase and program phases only if the flag is set; otherwise neither phase occurs.
- R2: A software save request (`sw_save` high for one cycle while idle with the supply good) always runs erase and program, whether or not the dirty flag is set.
- R3: When `hw_store_n` goes low while idle, a grace window of GRACE_CYC cycles follows. During it, reads are granted and a write that was granted in the cycle before (and is still held) stays granted. A write that starts after the pin fell is refused until the pin is high again.
- R4: `busy_oe` is high exactly while erase or program is active, and `busy_lvl` is always 0. After a save, or after a grace window with nothing to save, the block stays locked (no access granted) until `hw_store_n` is observed high.
- R5: A save holds `nv_erase` for ERASE_CYC cycles and then `nv_program` for PROG_CYC cycles. A restore holds `sram_clear` for CLEAR_CYC cycles and then `nv_copy` for COPY_CYC cycles. `done` is high for exactly one cycle, the first cycle after the final phase.
- R6: `supply_dead` high latches a pending restore. The restore starts in the cycle after `supply_ok` is high while idle, and not before.
- R7: No read or write is granted while any phase is active.
- R8: When requests coincide in an idle cycle, the order is: pending power-up restore first, then power-fail save, then pin save, then software save, then software restore. A software pulse that loses is dropped.
- R9: While `supply_ok` is low, no write is granted and software and pin requests are ignored.
- R10: Reset leaves the block idle with all phase strobes, `busy_oe`, `done` and grants low, the dirty flag clear and a restore pending. The restore runs once the supply is good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| supply_ok | input | 1 | Supply above switch threshold |
| supply_dead | input | 1 | Supply below reset threshold |
| hw_store_n | input | 1 | Observed level of the shared store/busy pin, low requests a save |
| sw_save | input | 1 | Software save command, one-cycle pulse |
| sw_restore | input | 1 | Software restore command, one-cycle pulse |
| sram_wr | input | 1 | Host write request, held for the write |
| sram_rd | input | 1 | Host read request |
| wr_ok | output | 1 | Write strobe granted to the SRAM |
| rd_ok | output | 1 | Read strobe granted to the SRAM |
| busy_oe | output | 1 | Open-drain enable for the busy pin |
| busy_lvl | output | 1 | Level driven when enabled (always 0) |
| nv_erase | output | 1 | Erase phase strobe |
| nv_program | output | 1 | Program phase strobe |
| sram_clear | output | 1 | SRAM clear phase strobe |
| nv_copy | output | 1 | Copy-to-SRAM phase strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives a table of eight cases: every trigger (software save, store pin, power-fail, software restore), each with the array clean and with it dirty. Per case it counts the cycles of each phase strobe, of busy and of done. This separates the triggers that depend on the dirty flag from those that do not, and it checks phase order and length. Directed sequences then cover the following:
- a write held across the falling store pin, followed by a fresh write inside the grace window, which shows the in-flight write is kept and the new one refused;
- coincident power-fail and pin requests, and a latched restore arriving together with a software save, which show the priority order;
- a latched restore held back while the supply stays low;
- access attempts made during the phases and during the lock.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GRACE,
        S_ERASE,
        S_PROG,
        S_CLEAR,
        S_COPY,
        S_LOCK
    } nv_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_PWR_RESTORE,
        K_PF_SAVE,
        K_PIN_SAVE,
        K_SW_SAVE,
        K_SW_RESTORE
    } nv_kind_e;

endpackage

// File: rtl/nvsr_arbiter.sv
module nvsr_arbiter
    import nvsr_pkg::*;
(
    input  logic     idle,
    input  logic     pend,
    input  logic     supply_ok,
    input  logic     dirty,
    input  logic     hw_store_n,
    input  logic     sw_save,
    input  logic     sw_restore,
    output nv_kind_e kind,
    output logic     imm
);

    // Fixed priority: power-up restore, power-fail save, pin save, software.
    always_comb begin
        kind = K_NONE;
        if (idle) begin
            if (pend && supply_ok)  kind = K_PWR_RESTORE;
            else if (!supply_ok)    kind = dirty ? K_PF_SAVE : K_NONE;
            else if (!hw_store_n)   kind = K_PIN_SAVE;
            else if (sw_save)       kind = K_SW_SAVE;
            else if (sw_restore)    kind = K_SW_RESTORE;
        end
        // Starts that take effect on the next edge (the pin save has a grace window).
        imm = (kind != K_NONE) && (kind != K_PIN_SAVE);
    end

endmodule

// File: rtl/nvsr_gate.sv
module nvsr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic in_idle,
    input  logic in_grace,
    input  logic imm,
    input  logic hw_store_n,
    input  logic supply_ok,
    input  logic sram_wr,
    input  logic sram_rd,
    output logic wr_ok,
    output logic rd_ok
);

    logic infl_d, infl_q;

    always_comb begin
        wr_ok  = supply_ok && sram_wr &&
                 ((in_idle && !imm && (hw_store_n || infl_q)) ||
                  (in_grace && infl_q));
        rd_ok  = sram_rd && ((in_idle && !imm) || in_grace);
        infl_d = wr_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) infl_q <= 1'b0;
        else        infl_q <= infl_d;
    end

    // R3: inside the grace window only a continuing write is granted
    a_r3_grace_no_new_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_grace && wr_ok) |-> $past(wr_ok));

    // R9: no write at low supply
    a_r9_low_supply_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !wr_ok);

endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl
    import nvsr_pkg::*;
#(
    parameter int GRACE_CYC = 8,
    parameter int ERASE_CYC = 16,
    parameter int PROG_CYC  = 32,
    parameter int CLEAR_CYC = 4,
    parameter int COPY_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic supply_dead,
    input  logic hw_store_n,
    input  logic sw_save,
    input  logic sw_restore,
    input  logic sram_wr,
    input  logic sram_rd,
    output logic wr_ok,
    output logic rd_ok,
    output logic busy_oe,
    output logic busy_lvl,
    output logic nv_erase,
    output logic nv_program,
    output logic sram_clear,
    output logic nv_copy,
    output logic done
);

    localparam int MAX_AB  = (GRACE_CYC > ERASE_CYC) ? GRACE_CYC : ERASE_CYC;
    localparam int MAX_CD  = (PROG_CYC > CLEAR_CYC) ? PROG_CYC : CLEAR_CYC;
    localparam int MAX_ABC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int MAXC    = (MAX_ABC > COPY_CYC) ? MAX_ABC : COPY_CYC;
    localparam int CW      = (MAXC > 1) ? $clog2(MAXC) : 1;

    localparam logic [CW-1:0] LD_GRACE = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] LD_ERASE = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] LD_PROG  = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] LD_CLEAR = CW'(CLEAR_CYC - 1);
    localparam logic [CW-1:0] LD_COPY  = CW'(COPY_CYC - 1);

    typedef struct packed {
        nv_state_e     st;
        logic [CW-1:0] cnt;
        logic          dirty;
        logic          pend;
        logic          done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: S_IDLE, cnt: '0, dirty: 1'b0, pend: 1'b1, done: 1'b0};

    ctl_t     r_d, r_q;
    nv_kind_e kind;
    logic     imm;
    logic     last;

    nvsr_arbiter u_arb (
        .idle       (r_q.st == S_IDLE),
        .pend       (r_q.pend),
        .supply_ok  (supply_ok),
        .dirty      (r_q.dirty),
        .hw_store_n (hw_store_n),
        .sw_save    (sw_save),
        .sw_restore (sw_restore),
        .kind       (kind),
        .imm        (imm)
    );

    nvsr_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_idle    (r_q.st == S_IDLE),
        .in_grace   (r_q.st == S_GRACE),
        .imm        (imm),
        .hw_store_n (hw_store_n),
        .supply_ok  (supply_ok),
        .sram_wr    (sram_wr),
        .sram_rd    (sram_rd),
        .wr_ok      (wr_ok),
        .rd_ok      (rd_ok)
    );

    assign last = (r_q.cnt == '0);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (wr_ok) r_d.dirty = 1'b1;

        unique case (r_q.st)
            S_IDLE: begin
                unique case (kind)
                    K_PWR_RESTORE: begin
                        r_d.st = S_CLEAR; r_d.cnt = LD_CLEAR;
                        r_d.dirty = 1'b0; r_d.pend = 1'b0;
                    end
                    K_SW_RESTORE: begin
                        r_d.st = S_CLEAR; r_d.cnt = LD_CLEAR; r_d.dirty = 1'b0;
                    end
                    K_PF_SAVE, K_SW_SAVE: begin
                        r_d.st = S_ERASE; r_d.cnt = LD_ERASE; r_d.dirty = 1'b0;
                    end
                    K_PIN_SAVE: begin
                        r_d.st = S_GRACE; r_d.cnt = LD_GRACE;
                    end
                    default: ;
                endcase
            end
            S_GRACE: begin
                if (!last)                       r_d.cnt = r_q.cnt - 1'b1;
                else if (r_q.dirty || wr_ok) begin
                    r_d.st = S_ERASE; r_d.cnt = LD_ERASE; r_d.dirty = 1'b0;
                end else                         r_d.st = S_LOCK;
            end
            S_ERASE: begin
                if (!last) r_d.cnt = r_q.cnt - 1'b1;
                else begin r_d.st = S_PROG; r_d.cnt = LD_PROG; end
            end
            S_PROG: begin
                if (!last) r_d.cnt = r_q.cnt - 1'b1;
                else begin r_d.st = S_LOCK; r_d.done = 1'b1; end
            end
            S_CLEAR: begin
                if (!last) r_d.cnt = r_q.cnt - 1'b1;
                else begin r_d.st = S_COPY; r_d.cnt = LD_COPY; end
            end
            S_COPY: begin
                if (!last) r_d.cnt = r_q.cnt - 1'b1;
                else begin r_d.st = S_IDLE; r_d.done = 1'b1; end
            end
            S_LOCK: begin
                if (hw_store_n) r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase

        if (supply_dead) r_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RST;
        else        r_q <= r_d;
    end

    assign nv_erase   = (r_q.st == S_ERASE);
    assign nv_program = (r_q.st == S_PROG);
    assign sram_clear = (r_q.st == S_CLEAR);
    assign nv_copy    = (r_q.st == S_COPY);
    assign busy_oe    = nv_erase || nv_program;
    assign busy_lvl   = 1'b0;
    assign done       = r_q.done;

    // R1: a clean array under power-fail never starts an erase
    a_r1_pf_clean_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && !supply_ok && !r_q.dirty) |=> !nv_erase);

    // R1: dirty flag is clear once a save or restore has begun
    a_r1_dirty_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(nv_erase) || $rose(sram_clear)) |-> !r_q.dirty);

    // R4: lock holds while the pin is low
    a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_LOCK && !hw_store_n) |=> (r_q.st == S_LOCK));

    // R5: erase is followed by program, clear by copy
    a_r5_erase_then_prog: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nv_erase) |-> nv_program);
    a_r5_clear_then_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_clear) |-> nv_copy);

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: no SRAM access while a phase or the lock is active
    a_r7_no_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_erase || nv_program || sram_clear || nv_copy || r_q.st == S_LOCK)
            |-> (!wr_ok && !rd_ok));

    // R8: a pending restore with good supply wins in an idle cycle
    a_r8_restore_first: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && r_q.pend && supply_ok) |=> sram_clear);

endmodule

// File: tb/sim_nvsr_ctrl.sv
module sim_nvsr_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int G = 3, E = 3, P = 4, C = 2, Y = 3;

    // {kind[1:0], dirty, expect_run}; kind 0 sw save, 1 pin, 2 power-fail, 3 sw restore
    localparam logic [3:0] SCN [8] = '{
        4'b0001, 4'b0011, 4'b0100, 4'b0111,
        4'b1000, 4'b1011, 4'b1101, 4'b1111
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic supply_ok = 1'b1, supply_dead = 1'b0, hw_store_n = 1'b1;
    logic sw_save = 1'b0, sw_restore = 1'b0, sram_wr = 1'b0, sram_rd = 1'b0;
    logic wr_ok, rd_ok, busy_oe, busy_lvl, nv_erase, nv_program, sram_clear, nv_copy, done;

    int nchk = 0, nerr = 0;
    bit mon = 1'b0;
    int c_er, c_pr, c_cl, c_cp, c_busy, c_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvsr_ctrl #(.GRACE_CYC(G), .ERASE_CYC(E), .PROG_CYC(P), .CLEAR_CYC(C), .COPY_CYC(Y)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .supply_dead(supply_dead),
        .hw_store_n(hw_store_n), .sw_save(sw_save), .sw_restore(sw_restore),
        .sram_wr(sram_wr), .sram_rd(sram_rd), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .busy_oe(busy_oe), .busy_lvl(busy_lvl), .nv_erase(nv_erase), .nv_program(nv_program),
        .sram_clear(sram_clear), .nv_copy(nv_copy), .done(done)
    );

    always @(negedge clk) if (mon) begin
        c_er   += int'(nv_erase);
        c_pr   += int'(nv_program);
        c_cl   += int'(sram_clear);
        c_cp   += int'(nv_copy);
        c_busy += int'(busy_oe);
        c_done += int'(done);
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clr_cnt();
        c_er = 0; c_pr = 0; c_cl = 0; c_cp = 0; c_busy = 0; c_done = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_scn(input logic [1:0] k, input logic d, input logic ex);
        string tg;
        bit sv, rs;
        tg = (k == 2'd0) ? "R2" : ((k == 2'd3) ? "R5" : "R1");
        sv = ex && (k != 2'd3);
        rs = ex && (k == 2'd3);
        clr_cnt();
        mon = 1'b1;
        if (d) begin
            cyc(1); sram_wr = 1'b1;
            cyc(1); sram_wr = 1'b0;
        end
        cyc(1);
        case (k)
            2'd0: begin sw_save = 1'b1; cyc(1); sw_save = 1'b0; end
            2'd1: hw_store_n = 1'b0;
            2'd2: supply_ok = 1'b0;
            default: begin sw_restore = 1'b1; cyc(1); sw_restore = 1'b0; end
        endcase
        cyc(20);
        hw_store_n = 1'b1; supply_ok = 1'b1;
        cyc(6);
        mon = 1'b0;
        chk(tg,   "erase cycles",   c_er,   sv ? E : 0);
        chk(tg,   "program cycles", c_pr,   sv ? P : 0);
        chk("R5", "clear cycles",   c_cl,   rs ? C : 0);
        chk("R5", "copy cycles",    c_cp,   rs ? Y : 0);
        chk("R4", "busy cycles",    c_busy, sv ? E + P : 0);
        chk("R5", "done pulses",    c_done, ex ? 1 : 0);
    endtask

    initial begin
        cyc(20000);
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        // R10 reset state
        cyc(3);
        #1;
        chk("R10", "busy_oe in reset", int'(busy_oe), 0);
        chk("R10", "phases in reset", int'(nv_erase | nv_program | sram_clear | nv_copy), 0);
        chk("R10", "done in reset", int'(done), 0);
        chk("R4",  "busy_lvl", int'(busy_lvl), 0);
        clr_cnt();
        mon = 1'b1;
        rst_n = 1'b1;
        cyc(15);
        mon = 1'b0;
        chk("R10", "power-up clear cycles", c_cl, C);
        chk("R10", "power-up copy cycles", c_cp, Y);
        chk("R10", "power-up erase cycles", c_er, 0);

        // table of trigger x dirty cases
        for (int i = 0; i < 8; i++) run_scn(SCN[i][3:2], SCN[i][1], SCN[i][0]);

        // R3 grace window
        cyc(1); sram_wr = 1'b1;
        cyc(1); hw_store_n = 1'b0; #1;
        chk("R3", "in-flight write at pin fall", int'(wr_ok), 1);
        cyc(1); #1;
        chk("R3", "in-flight write in grace", int'(wr_ok), 1);
        chk("R3", "no erase during grace", int'(nv_erase), 0);
        sram_wr = 1'b0; sram_rd = 1'b1; #1;
        chk("R3", "read in grace", int'(rd_ok), 1);
        cyc(1); sram_rd = 1'b0; sram_wr = 1'b1; #1;
        chk("R3", "new write in grace", int'(wr_ok), 0);
        sram_wr = 1'b0;
        cyc(12);
        sram_wr = 1'b1; sram_rd = 1'b1; #1;
        chk("R4", "busy released after save", int'(busy_oe), 0);
        chk("R4", "write in lock", int'(wr_ok), 0);
        chk("R4", "read in lock", int'(rd_ok), 0);
        sram_wr = 1'b0; sram_rd = 1'b0; hw_store_n = 1'b1;
        cyc(2); sram_wr = 1'b1; #1;
        chk("R4", "write after pin release", int'(wr_ok), 1);
        cyc(1); sram_wr = 1'b0;

        // R8 power-fail beats pin (array dirty)
        cyc(1); supply_ok = 1'b0; hw_store_n = 1'b0;
        cyc(1); #1;
        chk("R8", "power-fail erase without grace", int'(nv_erase), 1);
        cyc(12); hw_store_n = 1'b1; supply_ok = 1'b1;
        cyc(4);

        // R6 restore waits for good supply
        supply_ok = 1'b0; supply_dead = 1'b1;
        cyc(1); supply_dead = 1'b0;
        cyc(5); #1;
        chk("R6", "restore held while supply low", int'(sram_clear), 0);
        supply_ok = 1'b1;
        cyc(1); #1;
        chk("R6", "restore starts on good supply", int'(sram_clear), 1);
        cyc(8);

        // R8 pending restore beats software save
        supply_ok = 1'b0; supply_dead = 1'b1;
        cyc(1); supply_dead = 1'b0; supply_ok = 1'b1; sw_save = 1'b1;
        clr_cnt(); mon = 1'b1;
        cyc(1); sw_save = 1'b0; #1;
        chk("R8", "restore before sw save", int'(sram_clear), 1);
        cyc(10); mon = 1'b0;
        chk("R8", "losing sw save dropped", c_er, 0);

        // R7 access blocked during phases
        sw_save = 1'b1;
        cyc(1); sw_save = 1'b0; sram_wr = 1'b1; sram_rd = 1'b1; #1;
        chk("R7", "erase active", int'(nv_erase), 1);
        chk("R7", "write during erase", int'(wr_ok), 0);
        chk("R7", "read during erase", int'(rd_ok), 0);
        sram_wr = 1'b0; sram_rd = 1'b0;
        cyc(10);
        sw_restore = 1'b1;
        cyc(1); sw_restore = 1'b0; sram_rd = 1'b1; #1;
        chk("R7", "read during clear", int'(rd_ok), 0);
        sram_rd = 1'b0;
        cyc(8);

        // R9 low supply: no write, software save ignored
        supply_ok = 1'b0; sram_wr = 1'b1; #1;
        chk("R9", "write at low supply", int'(wr_ok), 0);
        sram_wr = 1'b0;
        clr_cnt(); mon = 1'b1;
        cyc(1); sw_save = 1'b1;
        cyc(1); sw_save = 1'b0;
        cyc(8); mon = 1'b0;
        chk("R9", "sw save at low supply", c_er, 0);
        supply_ok = 1'b1;
        cyc(2);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule